// File: doc/BRIEF.md
# CAN Global Status Tracker

This block keeps the global status flags of a CAN protocol controller. The host supplies its mode-control request levels: a halt request, a sleep request, a software reset request and two enables for halting automatically on bus-off. The protocol engine supplies a bit-tick strobe with the current bus phase and bit index, and event strobes for transmit start, arbitration lost, reception, bus-off entry and exit, and configuration done. From these inputs the block drives three registered status flags and a transmit-acknowledge pulse: halt/sleep, in-reset and transmitter-idle.

The flags do not follow register writes directly. They move at defined points on the bus: the acknowledge fires on the seventh bit of end-of-frame, and the transmitter returns to idle on the third bit of intermission. A halt takes effect only when the bus is between frames. Leaving sleep takes two further bus bit ticks before the halt/sleep flag drops. All flags change only on the system clock edge. The bus phase is encoded as 0 = in frame, 1 = end-of-frame, 2 = intermission, 3 = bus idle. The bit index counts from 0 within a phase, so index 6 is the seventh bit and index 2 is the third.

Top module: `can_status_tracker`

## Requirements
- R1: After the synchronous reset `rst`, stat_in_reset is 1, stat_tx_idle is 1, stat_halt_sleep is 0 and tx_ack_pulse is 0.
- R2: stat_in_reset is set at the edge after any cycle with sw_reset_req high, even if cfg_done is also high. It clears at the edge after a cycle with cfg_done high and sw_reset_req low, and otherwise holds.
- R3: While running, halt_req sets stat_halt_sleep at the next edge only when bus_phase is 2 (intermission) or 3 (idle). In phase 0 or 1 it waits. A halt that was not entered through bus-off clears at the edge after halt_req is low and sleep_req is low.
- R4: boff_enter with both boff_halt_en_a and boff_halt_en_b high sets stat_halt_sleep at the next edge, whatever halt_req is. That halt is held until boff_exit. With either enable low, bus-off entry leaves the flag at 0.
- R5: sleep_req has no effect on stat_halt_sleep while running. While halted, it enters sleep and the flag stays 1.
- R6: After sleep_req drops, stat_halt_sleep stays 1 through any number of system clocks until the second bit_tick. At the edge of that tick it clears if halt_req is low, and stays 1 (halted) if halt_req is high.
- R7: tx_start clears stat_tx_idle at the next edge. From boff_enter until boff_exit (or a reset), stat_tx_idle is 0 regardless of other events.
- R8: tx_ack_pulse is high for one cycle after a bit_tick with bus_phase 1 and bit_idx 6 while a transmission is active. No other phase or index, and no tick without an active transmission, produces it.
- R9: A bit_tick with bus_phase 2 and bit_idx 2 sets stat_tx_idle when tx_pending is low. It leaves a transmission active when tx_pending is high. Other intermission indices have no effect.
- R10: arb_lost, rx_event, bus_phase 3, sw_reset_req or entry into halt return stat_tx_idle to 1 at the next edge when not bus-off. A tx_start in the same cycle takes priority and keeps it at 0.
- R11: sw_reset_req forces stat_halt_sleep to 0 and ends bus-off at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| halt_req | input | 1 | Host halt request level |
| sleep_req | input | 1 | Host sleep request level |
| boff_halt_en_a | input | 1 | First enable for halting on bus-off |
| boff_halt_en_b | input | 1 | Second enable for halting on bus-off |
| sw_reset_req | input | 1 | Host software reset request level |
| cfg_done | input | 1 | Engine reports configuration complete |
| bit_tick | input | 1 | One-cycle strobe per bus bit |
| bus_phase | input | 2 | 0 frame, 1 end-of-frame, 2 intermission, 3 idle |
| bit_idx | input | IDX_W | Bit index within the phase, from 0 |
| tx_start | input | 1 | Transmission starts |
| tx_pending | input | 1 | Further messages wait for transmission |
| arb_lost | input | 1 | Arbitration lost strobe |
| rx_event | input | 1 | Reception strobe |
| boff_enter | input | 1 | Bus-off entry strobe |
| boff_exit | input | 1 | Bus-off recovery strobe |
| stat_halt_sleep | output | 1 | Halted or sleeping |
| stat_in_reset | output | 1 | In reset state |
| stat_tx_idle | output | 1 | Not bus-off and no transmission in progress |
| tx_ack_pulse | output | 1 | Successful transmission acknowledge |

## Verification
The bench sweeps every phase and bit index with a transmission active. A decoder with an off-by-one index would acknowledge on the sixth or eighth bit of end-of-frame, or free the transmitter at the wrong intermission bit. It sweeps the halt request over all four phases and all four enable pairs at bus-off entry. A design that halts mid-frame, or that auto-halts with only one enable set, shows up there. Wake-up is stepped clock by clock without ticks and then tick by tick, which catches a counter that counts system clocks or drops the flag one tick early. Same-cycle collisions are also forced: reset request with configuration done, and start with arbitration lost. These expose an inverted priority.

// File: rtl/can_gstat_pkg.sv
package can_gstat_pkg;
  typedef enum logic [1:0] {
    PH_FRAME = 2'd0,
    PH_EOF   = 2'd1,
    PH_INTM  = 2'd2,
    PH_IDLE  = 2'd3
  } bus_phase_e;

  typedef enum logic [1:0] {
    MD_RUN   = 2'd0,
    MD_HALT  = 2'd1,
    MD_SLEEP = 2'd2,
    MD_WAKE  = 2'd3
  } mode_e;
endpackage

// File: rtl/gs_mode_fsm.sv
module gs_mode_fsm
  import can_gstat_pkg::*;
#(
  parameter int WAKE_TICKS = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       sw_reset,
  input  logic       halt_req,
  input  logic       sleep_req,
  input  logic       auto_ok,
  input  logic       boff_enter,
  input  logic       boff_exit,
  input  logic       bit_tick,
  input  bus_phase_e phase,
  output logic       hs_flag,
  output logic       halt_enter
);
  localparam int CNT_W = $clog2(WAKE_TICKS + 1);
  localparam logic [CNT_W-1:0] LAST_TICK = CNT_W'(WAKE_TICKS - 1);

  mode_e            state, nxt;
  logic [CNT_W-1:0] cnt, cnt_nxt;
  logic             hold, hold_nxt;
  logic             between_frames;

  assign between_frames = (phase == PH_INTM) || (phase == PH_IDLE);

  always_comb begin
    nxt      = state;
    cnt_nxt  = cnt;
    hold_nxt = hold && !boff_exit;
    unique case (state)
      MD_RUN: begin
        if (boff_enter && auto_ok) begin
          nxt      = MD_HALT;
          hold_nxt = 1'b1;
        end else if (halt_req && between_frames) begin
          nxt = MD_HALT;
        end
      end
      MD_HALT: begin
        if (sleep_req)
          nxt = MD_SLEEP;
        else if (!halt_req && !hold_nxt)
          nxt = MD_RUN;
      end
      MD_SLEEP: begin
        if (!sleep_req) begin
          nxt     = MD_WAKE;
          cnt_nxt = '0;
        end
      end
      MD_WAKE: begin
        if (sleep_req) begin
          nxt = MD_SLEEP;
        end else if (bit_tick) begin
          cnt_nxt = cnt + 1'b1;
          if (cnt == LAST_TICK)
            nxt = (halt_req || hold_nxt) ? MD_HALT : MD_RUN;
        end
      end
      default: nxt = MD_RUN;
    endcase
    if (sw_reset) begin
      nxt      = MD_RUN;
      hold_nxt = 1'b0;
      cnt_nxt  = '0;
    end
  end

  assign halt_enter = (state == MD_RUN) && (nxt == MD_HALT);

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= MD_RUN;
      cnt     <= '0;
      hold    <= 1'b0;
      hs_flag <= 1'b0;
    end else begin
      state   <= nxt;
      cnt     <= cnt_nxt;
      hold    <= hold_nxt;
      hs_flag <= (nxt != MD_RUN);
    end
  end
endmodule

// File: rtl/gs_tx_track.sv
module gs_tx_track
  import can_gstat_pkg::*;
#(
  parameter int IDX_W    = 3,
  parameter int ACK_IDX  = 6,
  parameter int DONE_IDX = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sw_reset,
  input  logic             bit_tick,
  input  bus_phase_e       phase,
  input  logic [IDX_W-1:0] bit_idx,
  input  logic             tx_start,
  input  logic             tx_pending,
  input  logic             arb_lost,
  input  logic             rx_event,
  input  logic             boff_enter,
  input  logic             boff_exit,
  input  logic             halt_enter,
  output logic             tx_idle_flag,
  output logic             tx_ack
);
  localparam logic [IDX_W-1:0] ACK_POS  = IDX_W'(ACK_IDX);
  localparam logic [IDX_W-1:0] DONE_POS = IDX_W'(DONE_IDX);

  logic active, active_nxt;
  logic busoff, busoff_nxt;
  logic ack_point, done_point, release_ev;

  assign ack_point  = bit_tick && (phase == PH_EOF)  && (bit_idx == ACK_POS);
  assign done_point = bit_tick && (phase == PH_INTM) && (bit_idx == DONE_POS) && !tx_pending;
  assign release_ev = done_point || arb_lost || rx_event || (phase == PH_IDLE) || halt_enter;

  always_comb begin
    if (sw_reset)        active_nxt = 1'b0;
    else if (tx_start)   active_nxt = 1'b1;
    else if (release_ev) active_nxt = 1'b0;
    else                 active_nxt = active;

    if (sw_reset)        busoff_nxt = 1'b0;
    else if (boff_enter) busoff_nxt = 1'b1;
    else if (boff_exit)  busoff_nxt = 1'b0;
    else                 busoff_nxt = busoff;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active       <= 1'b0;
      busoff       <= 1'b0;
      tx_idle_flag <= 1'b1;
      tx_ack       <= 1'b0;
    end else begin
      active       <= active_nxt;
      busoff       <= busoff_nxt;
      tx_idle_flag <= !(active_nxt || busoff_nxt);
      tx_ack       <= ack_point && active && !sw_reset;
    end
  end
endmodule

// File: rtl/gs_reset_flag.sv
module gs_reset_flag (
  input  logic clk,
  input  logic rst,
  input  logic sw_reset,
  input  logic cfg_done,
  output logic in_reset
);
  always_ff @(posedge clk) begin
    if (rst)           in_reset <= 1'b1;
    else if (sw_reset) in_reset <= 1'b1;
    else if (cfg_done) in_reset <= 1'b0;
  end
endmodule

// File: rtl/can_status_tracker.sv
module can_status_tracker
  import can_gstat_pkg::*;
#(
  parameter int IDX_W      = 3,
  parameter int ACK_IDX    = 6,
  parameter int DONE_IDX   = 2,
  parameter int WAKE_TICKS = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             halt_req,
  input  logic             sleep_req,
  input  logic             boff_halt_en_a,
  input  logic             boff_halt_en_b,
  input  logic             sw_reset_req,
  input  logic             cfg_done,
  input  logic             bit_tick,
  input  logic [1:0]       bus_phase,
  input  logic [IDX_W-1:0] bit_idx,
  input  logic             tx_start,
  input  logic             tx_pending,
  input  logic             arb_lost,
  input  logic             rx_event,
  input  logic             boff_enter,
  input  logic             boff_exit,
  output logic             stat_halt_sleep,
  output logic             stat_in_reset,
  output logic             stat_tx_idle,
  output logic             tx_ack_pulse
);
  bus_phase_e phase;
  logic       halt_enter;
  logic       auto_ok;

  assign phase   = bus_phase_e'(bus_phase);
  assign auto_ok = boff_halt_en_a && boff_halt_en_b;

  gs_mode_fsm #(.WAKE_TICKS(WAKE_TICKS)) mode_i (
    .clk        (clk),
    .rst        (rst),
    .sw_reset   (sw_reset_req),
    .halt_req   (halt_req),
    .sleep_req  (sleep_req),
    .auto_ok    (auto_ok),
    .boff_enter (boff_enter),
    .boff_exit  (boff_exit),
    .bit_tick   (bit_tick),
    .phase      (phase),
    .hs_flag    (stat_halt_sleep),
    .halt_enter (halt_enter)
  );

  gs_tx_track #(.IDX_W(IDX_W), .ACK_IDX(ACK_IDX), .DONE_IDX(DONE_IDX)) tx_i (
    .clk          (clk),
    .rst          (rst),
    .sw_reset     (sw_reset_req),
    .bit_tick     (bit_tick),
    .phase        (phase),
    .bit_idx      (bit_idx),
    .tx_start     (tx_start),
    .tx_pending   (tx_pending),
    .arb_lost     (arb_lost),
    .rx_event     (rx_event),
    .boff_enter   (boff_enter),
    .boff_exit    (boff_exit),
    .halt_enter   (halt_enter),
    .tx_idle_flag (stat_tx_idle),
    .tx_ack       (tx_ack_pulse)
  );

  gs_reset_flag rflag_i (
    .clk      (clk),
    .rst      (rst),
    .sw_reset (sw_reset_req),
    .cfg_done (cfg_done),
    .in_reset (stat_in_reset)
  );
endmodule

// File: rtl/can_status_tracker_chk.sv
module can_status_tracker_chk #(
  parameter int IDX_W   = 3,
  parameter int ACK_IDX = 6
) (
  input logic             clk,
  input logic             rst,
  input logic             halt_req,
  input logic             sleep_req,
  input logic             boff_halt_en_a,
  input logic             boff_halt_en_b,
  input logic             sw_reset_req,
  input logic             cfg_done,
  input logic             bit_tick,
  input logic [1:0]       bus_phase,
  input logic [IDX_W-1:0] bit_idx,
  input logic             tx_start,
  input logic             tx_pending,
  input logic             arb_lost,
  input logic             rx_event,
  input logic             boff_enter,
  input logic             boff_exit,
  input logic             stat_halt_sleep,
  input logic             stat_in_reset,
  input logic             stat_tx_idle,
  input logic             tx_ack_pulse
);
  // R2
  reset_set_chk: assert property (@(posedge clk) disable iff (rst)
    sw_reset_req |=> stat_in_reset);

  // R2
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(stat_in_reset) |-> $past(cfg_done && !sw_reset_req));

  // R3
  halt_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(stat_halt_sleep) |-> $past(halt_req || (boff_enter && boff_halt_en_a && boff_halt_en_b)));

  // R6
  halt_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(stat_halt_sleep) |-> $past(!sleep_req || sw_reset_req));

  // R7
  tx_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_start && !sw_reset_req) |=> !stat_tx_idle);

  // R8
  ack_point_chk: assert property (@(posedge clk) disable iff (rst)
    tx_ack_pulse |-> $past(bit_tick && (bus_phase == 2'd1) && (bit_idx == IDX_W'(ACK_IDX))));
endmodule

bind can_status_tracker can_status_tracker_chk #(.IDX_W(IDX_W), .ACK_IDX(ACK_IDX)) chk_i (.*);

// File: tb/can_status_tracker_tb_top.sv
`timescale 1ns/1ps
module can_status_tracker_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic halt_req = 0, sleep_req = 0, boff_halt_en_a = 0, boff_halt_en_b = 0;
  logic sw_reset_req = 0, cfg_done = 0, bit_tick = 0;
  logic [1:0] bus_phase = 2'd0;
  logic [2:0] bit_idx = 3'd0;
  logic tx_start = 0, tx_pending = 0, arb_lost = 0, rx_event = 0;
  logic boff_enter = 0, boff_exit = 0;
  logic stat_halt_sleep, stat_in_reset, stat_tx_idle, tx_ack_pulse;
  int n_cmp = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  can_status_tracker dut_i (.*);

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input logic got, input logic exp, input string tag);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0b expected %0b", tag, got, exp);
    end
  endtask

  task automatic tick(input logic [1:0] ph, input logic [2:0] idx);
    bit_tick = 1; bus_phase = ph; bit_idx = idx;
    cyc();
    bit_tick = 0; bus_phase = 2'd0; bit_idx = 3'd0;
  endtask

  task automatic start_tx();
    tx_start = 1; cyc(); tx_start = 0;
  endtask

  task automatic pulse_arb();
    arb_lost = 1; cyc(); arb_lost = 0;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    repeat (3) cyc();
    rst = 0;
    // R1 reset values
    chk(stat_in_reset, 1'b1, "R1 in_reset");
    chk(stat_tx_idle, 1'b1, "R1 tx_idle");
    chk(stat_halt_sleep, 1'b0, "R1 halt_sleep");
    chk(tx_ack_pulse, 1'b0, "R1 ack");

    // R2 clear by cfg_done
    cfg_done = 1; cyc(); cfg_done = 0;
    chk(stat_in_reset, 1'b0, "R2 clear");

    // R8 phase x index sweep with active transmission
    tx_pending = 1;
    for (int ph = 0; ph < 4; ph++) begin
      for (int ix = 0; ix < 8; ix++) begin
        start_tx();
        chk(stat_tx_idle, 1'b0, "R7 start");
        tick(2'(ph), 3'(ix));
        chk(tx_ack_pulse, (ph == 1 && ix == 6), $sformatf("R8 ph%0d ix%0d", ph, ix));
        chk(stat_tx_idle, (ph == 3), $sformatf("R10 idle-phase ph%0d ix%0d", ph, ix));
        pulse_arb();
        chk(tx_ack_pulse, 1'b0, "R8 one-cycle");
        chk(stat_tx_idle, 1'b1, "R10 arb_lost");
      end
    end
    // R8 no ack without transmission
    tick(2'd1, 3'd6);
    chk(tx_ack_pulse, 1'b0, "R8 no tx");

    // R9 intermission index x pending sweep
    for (int p = 0; p < 2; p++) begin
      for (int ix = 0; ix < 8; ix++) begin
        tx_pending = p[0];
        start_tx();
        tick(2'd2, 3'(ix));
        chk(stat_tx_idle, (ix == 2 && p == 0), $sformatf("R9 pend%0d ix%0d", p, ix));
        rx_event = 1; cyc(); rx_event = 0;
        chk(stat_tx_idle, 1'b1, "R10 rx_event");
      end
    end
    tx_pending = 0;

    // R10 start beats arb_lost in the same cycle
    tx_start = 1; arb_lost = 1; cyc(); tx_start = 0; arb_lost = 0;
    chk(stat_tx_idle, 1'b0, "R10 start priority");
    pulse_arb();

    // R7 bus-off holds tx idle low
    boff_enter = 1; cyc(); boff_enter = 0;
    chk(stat_tx_idle, 1'b0, "R7 busoff");
    chk(stat_halt_sleep, 1'b0, "R4 no enables");
    pulse_arb();
    chk(stat_tx_idle, 1'b0, "R7 busoff arb");
    boff_exit = 1; cyc(); boff_exit = 0;
    chk(stat_tx_idle, 1'b1, "R7 busoff exit");

    // R3 halt against each phase
    for (int ph = 0; ph < 4; ph++) begin
      halt_req = 1; bus_phase = 2'(ph);
      cyc(); cyc();
      chk(stat_halt_sleep, (ph >= 2), $sformatf("R3 halt ph%0d", ph));
      halt_req = 0; bus_phase = 2'd0;
      cyc();
      chk(stat_halt_sleep, 1'b0, "R3 release");
    end
    // R10 halt entry frees transmitter
    start_tx();
    halt_req = 1; bus_phase = 2'd2; cyc(); bus_phase = 2'd0;
    chk(stat_halt_sleep, 1'b1, "R3 halt in intm");
    chk(stat_tx_idle, 1'b1, "R10 halt entry");
    halt_req = 0; cyc();

    // R4 enable pair sweep at bus-off entry
    for (int e = 0; e < 4; e++) begin
      boff_halt_en_a = e[0]; boff_halt_en_b = e[1];
      boff_enter = 1; cyc(); boff_enter = 0;
      cyc(); cyc();
      chk(stat_halt_sleep, (e == 3), $sformatf("R4 en%0d", e));
      chk(stat_tx_idle, 1'b0, "R7 busoff sweep");
      boff_exit = 1; cyc(); boff_exit = 0;
      chk(stat_halt_sleep, 1'b0, $sformatf("R4 exit en%0d", e));
      chk(stat_tx_idle, 1'b1, "R7 exit sweep");
    end
    boff_halt_en_a = 0; boff_halt_en_b = 0;

    // R5 sleep ignored while running
    sleep_req = 1; repeat (3) cyc();
    chk(stat_halt_sleep, 1'b0, "R5 sleep while running");
    sleep_req = 0; cyc();

    // R5/R6 sleep then wake, halt released
    halt_req = 1; bus_phase = 2'd3; cyc(); bus_phase = 2'd0;
    sleep_req = 1; cyc(); halt_req = 0; cyc();
    chk(stat_halt_sleep, 1'b1, "R5 asleep");
    sleep_req = 0; repeat (5) cyc();
    chk(stat_halt_sleep, 1'b1, "R6 no ticks yet");
    tick(2'd0, 3'd0);
    chk(stat_halt_sleep, 1'b1, "R6 first tick");
    tick(2'd0, 3'd1);
    chk(stat_halt_sleep, 1'b0, "R6 second tick");

    // R6 wake with halt still requested stays halted
    halt_req = 1; bus_phase = 2'd3; cyc(); bus_phase = 2'd0;
    sleep_req = 1; cyc(); sleep_req = 0; cyc();
    tick(2'd0, 3'd0); tick(2'd0, 3'd1); cyc();
    chk(stat_halt_sleep, 1'b1, "R6 back to halt");
    halt_req = 0; cyc();
    chk(stat_halt_sleep, 1'b0, "R3 halt drop after wake");

    // R11 software reset while halted and bus-off
    boff_halt_en_a = 1; boff_halt_en_b = 1;
    boff_enter = 1; cyc(); boff_enter = 0;
    chk(stat_halt_sleep, 1'b1, "R4 auto halt");
    sw_reset_req = 1; cfg_done = 1; cyc();
    chk(stat_halt_sleep, 1'b0, "R11 halt cleared");
    chk(stat_tx_idle, 1'b1, "R11 busoff cleared");
    chk(stat_in_reset, 1'b1, "R2 set beats cfg_done");
    sw_reset_req = 0; cfg_done = 0; cyc();
    chk(stat_in_reset, 1'b1, "R2 hold");
    cfg_done = 1; cyc(); cfg_done = 0;
    chk(stat_in_reset, 1'b0, "R2 clear after reset");
    boff_halt_en_a = 0; boff_halt_en_b = 0;

    summary();
    $finish;
  end
endmodule